// File: doc/BRIEF.md
# Clock-Enable Divider Tree

This block turns one fast reference clock into three clock-enable strobes for a core domain, a system-bus domain and a slow peripheral-bus domain. Each strobe is high for one reference cycle every N advance cycles, where N comes from a coded field of a 32-bit configuration word. Core and bus ratios divide the base advance directly. The peripheral ratio divides the bus strobe, so the peripheral domain is a sub-multiple of the bus domain.

The block runs in two modes. With the PLL-running flag of the configuration word set, the dividers advance on every reference cycle. With the flag clear, the block stands in for a bypassed PLL and advances only on cycles where the crystal-rate strobe `xtal_tick` is high. A new configuration word only takes effect on a cycle where all three counters sit at zero, so the three strobes never lose their common phase.

Top module: `clk_tree_div`

## Requirements
- R1: The core ratio field is `cfg_word[27:25]`; codes 0,1,2,3,4 give ratios 1,2,4,8,16 and codes 5,6,7 give ratio 1. With a ratio a applied at an aligned point, `core_en` is high after the k-th advance since that point exactly when k is a multiple of a.
- R2: The bus ratio field is `cfg_word[22:20]`; codes 0 to 7 give ratios 1,2,4,5,6,8,16,32. `bus_en` is high after the k-th advance since the aligned point exactly when k is a multiple of the bus ratio b.
- R3: The peripheral ratio field is `cfg_word[19:18]`; codes 0 to 3 give ratios 1,2,4,8 counted in bus strobes, so `per_en` is high after the k-th advance exactly when k is a multiple of b times the peripheral ratio.
- R4: When `cfg_word[23]` (PLL running) is 0, the counters advance only on cycles with `xtal_tick` high and all three outputs stay low after a cycle without a tick; when it is 1, every cycle is an advance and `xtal_tick` is ignored.
- R5: A ratio of 1 gives an enable that is high after every advance cycle, so in PLL mode it is continuously high.
- R6: `per_en` is never high unless `bus_en` is high in the same cycle.
- R7: A configuration word (including the mode flag) takes effect only at an aligned point: a cycle where the core, bus and peripheral counters are all at zero; between such points, changes on `cfg_word` have no effect on the outputs.
- R8: While `rst` is high all outputs are low and all counters return to zero; the configuration present at the first cycle after reset is applied at once.
- R9: Bits of `cfg_word` outside 27:25, 23 and 22:18 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at PLL rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration word holding the three ratio codes and the PLL-running flag |
| xtal_tick | input | 1 | Crystal-rate advance strobe used while the PLL is bypassed |
| core_en | output | 1 | Core clock-enable strobe, registered |
| bus_en | output | 1 | Bus clock-enable strobe, registered |
| per_en | output | 1 | Peripheral clock-enable strobe, registered |

## Verification
A counter that slips or skips a state shows at the ports as a strobe one or more cycles off its multiple of the advance count, visible on the very next strobe of that domain, at most 256 advances later for the peripheral chain. A configuration applied outside an aligned point shows as a strobe spacing that matches neither the old nor the new ratio, and a peripheral counter that is not gated by the bus strobe shows as `per_en` without `bus_en`, both within one peripheral period. The bench sweeps every combination of the three ratio codes in PLL mode and a spread of them under an irregular crystal tick, predicting every output cycle from the advance count since the last aligned point.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CFG_W     = 32;
    localparam int RATIO_W   = 6;
    localparam int NUM_DOM   = 3;
    localparam int DOM_CORE  = 0;
    localparam int DOM_BUS   = 1;
    localparam int DOM_PER   = 2;

    localparam int CORE_MSB  = 27;
    localparam int CORE_LSB  = 25;
    localparam int PLL_BIT   = 23;
    localparam int BUS_MSB   = 22;
    localparam int BUS_LSB   = 20;
    localparam int PER_MSB   = 19;
    localparam int PER_LSB   = 18;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        logic   pll_on;
        ratio_t core;
        ratio_t bus;
        ratio_t per;
    } ratio_set_t;

    function automatic ratio_t core_ratio(input logic [2:0] code);
        ratio_t r;
        case (code)
            3'd0:    r = ratio_t'(1);
            3'd1:    r = ratio_t'(2);
            3'd2:    r = ratio_t'(4);
            3'd3:    r = ratio_t'(8);
            3'd4:    r = ratio_t'(16);
            default: r = ratio_t'(1);
        endcase
        return r;
    endfunction

    function automatic ratio_t bus_ratio(input logic [2:0] code);
        ratio_t r;
        case (code)
            3'd0:    r = ratio_t'(1);
            3'd1:    r = ratio_t'(2);
            3'd2:    r = ratio_t'(4);
            3'd3:    r = ratio_t'(5);
            3'd4:    r = ratio_t'(6);
            3'd5:    r = ratio_t'(8);
            3'd6:    r = ratio_t'(16);
            default: r = ratio_t'(32);
        endcase
        return r;
    endfunction

    function automatic ratio_t per_ratio(input logic [1:0] code);
        return ratio_t'(1) << code;
    endfunction

    function automatic ratio_set_t decode_cfg(input logic [CFG_W-1:0] w);
        ratio_set_t s;
        s.pll_on = w[PLL_BIT];
        s.core   = core_ratio(w[CORE_MSB:CORE_LSB]);
        s.bus    = bus_ratio(w[BUS_MSB:BUS_LSB]);
        s.per    = per_ratio(w[PER_MSB:PER_LSB]);
        return s;
    endfunction

endpackage

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] ratio,
    output logic         at_zero,
    output logic         wrap
);

    logic [W-1:0] cnt_q;
    logic         last;

    assign last    = (cnt_q == ratio - W'(1));
    assign wrap    = adv && last;
    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= last ? '0 : cnt_q + W'(1);
        end
    end

    // R7: the ratio only changes when the count is zero, so the count never reaches it
    p_cnt_below_ratio_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q < ratio);

endmodule

// File: rtl/clkdiv_cfg_hold.sv
module clkdiv_cfg_hold
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             aligned,
    output ratio_set_t       eff
);

    ratio_set_t act_q;
    ratio_set_t fresh;

    assign fresh = decode_cfg(cfg_word);
    assign eff   = aligned ? fresh : act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= fresh;
        end else begin
            act_q <= eff;
        end
    end

endmodule

// File: rtl/clk_tree_div.sv
module clk_tree_div
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             xtal_tick,
    output logic             core_en,
    output logic             bus_en,
    output logic             per_en
);

    ratio_set_t         eff;
    logic               base_adv;
    logic               aligned;
    ratio_t             ratio_arr [NUM_DOM];
    logic [NUM_DOM-1:0] adv_v;
    logic [NUM_DOM-1:0] zero_v;
    logic [NUM_DOM-1:0] wrap_v;

    assign aligned  = &zero_v;
    assign base_adv = eff.pll_on | xtal_tick;

    assign ratio_arr[DOM_CORE] = eff.core;
    assign ratio_arr[DOM_BUS]  = eff.bus;
    assign ratio_arr[DOM_PER]  = eff.per;

    clkdiv_cfg_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .cfg_word (cfg_word),
        .aligned  (aligned),
        .eff      (eff)
    );

    for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
        if (i == DOM_PER) begin : g_cascade
            assign adv_v[i] = wrap_v[DOM_BUS];
        end else begin : g_base
            assign adv_v[i] = base_adv;
        end

        clkdiv_counter #(.W(RATIO_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .adv     (adv_v[i]),
            .ratio   (ratio_arr[i]),
            .at_zero (zero_v[i]),
            .wrap    (wrap_v[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_en <= 1'b0;
            bus_en  <= 1'b0;
            per_en  <= 1'b0;
        end else begin
            core_en <= wrap_v[DOM_CORE];
            bus_en  <= wrap_v[DOM_BUS];
            per_en  <= wrap_v[DOM_PER];
        end
    end

    // R6: peripheral strobe always rides on a bus strobe
    p_per_within_bus_r6: assert property (@(posedge clk) disable iff (rst)
        per_en |-> bus_en);

    // R5: unit ratio strobes on every advance
    p_unit_ratio_r5: assert property (@(posedge clk) disable iff (rst)
        (base_adv && eff.core == ratio_t'(1)) |=> core_en);

    // R4: in bypass, a cycle without a crystal tick yields no strobe
    p_bypass_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!eff.pll_on && !xtal_tick) |=> !(core_en || bus_en || per_en));

    // R3: peripheral strobe only when the bus counter wraps
    p_per_needs_bus_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        wrap_v[DOM_PER] |-> wrap_v[DOM_BUS]);

endmodule

// File: tb/clk_tree_div_bench.sv
module clk_tree_div_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = 32'h0;
    logic        xtal_tick = 1'b0;
    logic        core_en, bus_en, per_en;

    int n_checks = 0;
    int n_fail   = 0;

    int m_core = 1, m_bus = 1, m_per = 1, m_pll = 1;
    int t = 0;
    int e_core = 0, e_bus = 0, e_per = 0;
    string tag_core = "R1", tag_bus = "R2", tag_per = "R3";

    always #5 clk = ~clk;

    clk_tree_div u_clk_tree_div (
        .clk       (clk),
        .rst       (rst),
        .cfg_word  (cfg_word),
        .xtal_tick (xtal_tick),
        .core_en   (core_en),
        .bus_en    (bus_en),
        .per_en    (per_en)
    );

    function automatic int core_r(int c);
        return (c < 5) ? (1 << c) : 1;
    endfunction

    function automatic int bus_r(int c);
        if (c < 3) return 1 << c;
        if (c == 3) return 5;
        if (c == 4) return 6;
        return 1 << (c - 2);
    endfunction

    function automatic int lcm(int a, int b);
        int x = a;
        int y = b;
        while (y != 0) begin
            int r = x % y;
            x = y;
            y = r;
        end
        return (a / x) * b;
    endfunction

    // field positions per R1..R4; junk in the low bits exercises R9
    function automatic logic [31:0] mk(int c, int b, int p, int pll, logic [17:0] junk);
        logic [31:0] w = 32'h0;
        w[27:25] = 3'(c);
        w[23]    = 1'(pll);
        w[22:20] = 3'(b);
        w[19:18] = 2'(p);
        w[17:0]  = junk;
        w[31:28] = 4'(junk[3:0]);
        w[24]    = junk[5];
        return w;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0d", req, act, exp, $time);
        end
    endtask

    task automatic step(logic [31:0] w, logic tk);
        int adv;
        cfg_word  = w;
        xtal_tick = tk;
        if (t % lcm(m_core, m_bus * m_per) == 0) begin
            m_core = core_r(int'(w[27:25]));
            m_bus  = bus_r(int'(w[22:20]));
            m_per  = 1 << w[19:18];
            m_pll  = int'(w[23]);
            t = 0;
        end
        adv = (m_pll != 0 || tk) ? 1 : 0;
        if (adv != 0) t++;
        e_core = (adv != 0 && t % m_core == 0) ? 1 : 0;
        e_bus  = (adv != 0 && t % m_bus == 0) ? 1 : 0;
        e_per  = (adv != 0 && t % (m_bus * m_per) == 0) ? 1 : 0;
        @(posedge clk);
        @(negedge clk);
        check(tag_core, int'(core_en), e_core);
        check(tag_bus, int'(bus_en), e_bus);
        check(tag_per, int'(per_en), e_per);
        check("R6", int'(per_en && !bus_en), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        cfg_word = mk(2, 3, 1, 1, 18'h2A5A5);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8: reset quiet
        check("R8", int'(core_en), 0);
        check("R8", int'(bus_en), 0);
        check("R8", int'(per_en), 0);
        rst = 1'b0;
        t = 0;

        // PLL mode: every code combination, R1 R2 R3 R9
        for (int c = 0; c < 8; c++) begin
            for (int b = 0; b < 8; b++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int k = 0; k < 300; k++) begin
                        logic [17:0] j = 18'(k * 7919 + c * 131 + b);
                        step(mk(c, b, p, 1, j), 1'(k % 2));
                    end
                end
            end
        end

        // bypass mode with irregular crystal tick, R4
        tag_core = "R4"; tag_bus = "R4"; tag_per = "R4";
        for (int i = 0; i < 32; i++) begin
            for (int k = 0; k < 400; k++) begin
                logic tk = ((k % 3) == 0) ^ ((k % 7) == 0);
                step(mk(i % 8, (i * 3) % 8, i % 4, 0, 18'(k)), tk);
            end
        end

        // R7: slowest setting, then change early in its period
        tag_core = "R7"; tag_bus = "R7"; tag_per = "R7";
        for (int k = 0; k < 600; k++) step(mk(4, 7, 3, 1, 18'h0), 1'b0);
        for (int k = 0; k < 40; k++) step(mk(4, 7, 3, 1, 18'h0), 1'b0);
        for (int k = 0; k < 400; k++) step(mk(0, 3, 0, 1, 18'h0), 1'b0);

        // R5: aliased unit ratio, all ratio 1 -> continuous enables
        tag_core = "R5"; tag_bus = "R5"; tag_per = "R5";
        for (int k = 0; k < 60; k++) step(mk(6, 0, 0, 1, 18'h3FFFF), 1'b0);
        for (int k = 0; k < 20; k++) begin
            step(mk(7, 0, 0, 1, 18'h1234), 1'b0);
            check("R5", int'(core_en & bus_en & per_en), 1);
        end

        // R8: reset again mid-run clears outputs
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8", int'(core_en | bus_en | per_en), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule